// File: doc/BRIEF.md
# PCI Base Address Register Bank

This block holds six 32-bit base address registers for a PCI-style configuration header. Each register is built for one fixed window. A parameter sets the window's size, which must be a power of two. Parameters also choose between a memory window and an I/O window, and set the memory attribute bits. Only the address bits at or above the window size exist as flops. Every bit below that point is tied to zero.

Software learns the window size with a probe. It writes all ones and reads the register back, and the value returned is the bitwise complement of size minus one. Software then writes the real base address, which is kept through the same bit mask. The block has no separate sizing state. The probe result follows only from which bits are implemented.

Access goes through one register port. The port carries a register index, write data with byte enables, and a read strobe. Read data comes back one clock after the strobe, together with a valid flag. Size parameters that are not legal stop the build at elaboration.

Top module: `bar_bank`

## Requirements
- R1: After reset, every register reads as a zero address field with its encoding bits at their configured values.
- R2: A full-width write of 0xFFFFFFFF makes the next read of that register return ~(size-1) in the address field, combined with the encoding bits. For example, a 0x1000 memory window with zero attributes reads back as 0xFFFFF000.
- R3: A write of any other value keeps only the implemented address bits. Bits below the window size read as zero. A base address written back after a probe is returned on later reads.
- R4: Bit 0 of a memory register always reads 0. Bits 3:1 always read the configured attribute value, whatever data is written.
- R5: Bit 0 of an I/O register always reads 1, and bit 1 always reads 0.
- R6: An I/O register built with a 16-bit decode always reads zero in bits 31:16. Its probe result in bits 15:0 gives the size: invert those 16 bits and add one.
- R7: A write changes only the bytes whose enables are set. Byte 0 is enabled by bit 0 and byte 3 by bit 3. The changed bytes still pass through the implemented-bit mask.
- R8: Index 0 to 5 selects a register. A write to index 6 or 7 changes no register, and a read of index 6 or 7 returns zero.
- R9: The valid flag rises, and read data appears, one clock after a read strobe. The valid flag is low in any cycle not preceded by a strobe. A read and a write to the same register in the same cycle return the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| idx_i | input | 3 | Register index for the access |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| wr_be_i | input | 4 | Byte enables for the write |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 32 | Read data, one clock after the strobe |
| rd_valid_o | output | 1 | High when rd_data_o holds a read result |

## Verification
A wrong mask shows up on the first read after a probe write. The read returns a size that is too large or too small, or ones below the window boundary, one clock after the read strobe. A corrupted encoding bit or a bad byte-lane merge can be seen on the very next read of that register. A wrong decode of the write index shows up when a register that should have stayed unchanged is read back.

// File: rtl/bar_bank_pkg.sv
package bar_bank_pkg;
  localparam int NUM_BARS = 6;
  localparam int IDX_W    = 3;
  localparam int BAR_W    = 32;
  localparam int BE_W     = BAR_W / 8;
  typedef logic [BAR_W-1:0] bar_word_t;
endpackage

// File: rtl/bar_slot.sv
module bar_slot
  import bar_bank_pkg::*;
#(
  parameter logic [31:0] SIZE     = 32'h0000_1000,
  parameter bit          IS_IO    = 1'b0,
  parameter bit          IO16     = 1'b0,
  parameter logic [2:0]  MEM_ATTR = 3'b000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  bar_word_t       wr_data_i,
  input  logic [BE_W-1:0] wr_be_i,
  output bar_word_t       val_o
);
  localparam logic [31:0] MIN_SIZE  = IS_IO ? 32'd4 : 32'd16;
  localparam logic [31:0] LOW_MASK  = IS_IO ? 32'hFFFF_FFFC : 32'hFFFF_FFF0;
  localparam logic [31:0] HI_MASK   = (IS_IO && IO16) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  localparam logic [31:0] ADDR_MASK = ~(SIZE - 32'd1) & LOW_MASK & HI_MASK;
  localparam logic [31:0] ENC       = IS_IO ? 32'h0000_0001 : {28'h0, MEM_ATTR, 1'b0};

  // reject illegal window sizes at elaboration
  if (((SIZE & (SIZE - 32'd1)) != 32'd0) || (SIZE < MIN_SIZE)) begin : g_bad_size
    $error("bar_slot: SIZE must be a power of two at or above the minimum");
  end
  if (IS_IO && IO16 && (SIZE > 32'h0001_0000)) begin : g_bad_io16
    $error("bar_slot: 16-bit I/O window larger than 64K");
  end

  bar_word_t addr_q;
  bar_word_t merged;

  for (genvar b = 0; b < BE_W; b++) begin : g_lane
    assign merged[8*b +: 8] = wr_be_i[b] ? wr_data_i[8*b +: 8] : addr_q[8*b +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   addr_q <= '0;
    else if (wr_i) addr_q <= merged & ADDR_MASK;
  end

  assign val_o = addr_q | ENC;

  // R2
  probe_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wr_be_i == '1 && wr_data_i == '1) |=> (val_o == (ADDR_MASK | ENC)));
  // R4
  enc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> ((val_o & ~ADDR_MASK) == ENC));
  // R3
  idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(val_o));
  // R7
  lane0_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !wr_be_i[0]) |=> (val_o[7:0] == $past(val_o[7:0])));
endmodule

// File: rtl/bar_rd_port.sv
module bar_rd_port
  import bar_bank_pkg::*;
(
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        rd_en_i,
  input  logic [IDX_W-1:0]            idx_i,
  input  bar_word_t [NUM_BARS-1:0]    vals_i,
  output bar_word_t                   rd_data_o,
  output logic                        rd_valid_o
);
  logic      hit;
  bar_word_t sel;

  assign hit = (idx_i < IDX_W'(NUM_BARS));

  always_comb begin
    sel = '0;
    for (int i = 0; i < NUM_BARS; i++)
      if (idx_i == IDX_W'(i)) sel = vals_i[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i) rd_data_o <= hit ? sel : '0;
    end
  end

  // R9
  rd_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rd_valid_o);
  // R9
  rd_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !rd_valid_o);
  // R8
  oob_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !hit) |=> (rd_data_o == '0));
endmodule

// File: rtl/bar_bank.sv
module bar_bank
  import bar_bank_pkg::*;
#(
  parameter logic [NUM_BARS-1:0][31:0] BAR_SIZE = {32'h0001_0000, 32'h0000_0010, 32'h0000_0020,
                                                   32'h0000_0100, 32'h0010_0000, 32'h0000_1000},
  parameter logic [NUM_BARS-1:0]       BAR_IO   = 6'b00_1100,
  parameter logic [NUM_BARS-1:0]       BAR_IO16 = 6'b00_0100,
  parameter logic [NUM_BARS-1:0][2:0]  BAR_ATTR = {3'b010, 3'b000, 3'b000, 3'b000, 3'b100, 3'b000}
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             wr_en_i,
  input  logic [BAR_W-1:0] wr_data_i,
  input  logic [BE_W-1:0]  wr_be_i,
  input  logic             rd_en_i,
  output logic [BAR_W-1:0] rd_data_o,
  output logic             rd_valid_o
);
  bar_word_t [NUM_BARS-1:0] vals;
  logic      [NUM_BARS-1:0] wr_sel;

  for (genvar g = 0; g < NUM_BARS; g++) begin : g_bar
    assign wr_sel[g] = wr_en_i && (idx_i == IDX_W'(g));
    bar_slot #(
      .SIZE     (BAR_SIZE[g]),
      .IS_IO    (BAR_IO[g]),
      .IO16     (BAR_IO16[g]),
      .MEM_ATTR (BAR_ATTR[g])
    ) i_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (wr_sel[g]),
      .wr_data_i (wr_data_i),
      .wr_be_i   (wr_be_i),
      .val_o     (vals[g])
    );
  end

  bar_rd_port i_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_en_i    (rd_en_i),
    .idx_i      (idx_i),
    .vals_i     (vals),
    .rd_data_o  (rd_data_o),
    .rd_valid_o (rd_valid_o)
  );

  // R8
  oob_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && idx_i >= IDX_W'(NUM_BARS)) |=> $stable(vals));
  // R8
  one_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_sel));
endmodule

// File: tb/test_bar_bank.sv
`timescale 1ns/1ps
module test_bar_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  idx = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [3:0]  wr_be = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic        rd_valid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bar_bank i_bar_bank (
    .clk_i(clk), .rst_ni(rst_n), .idx_i(idx), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .wr_be_i(wr_be), .rd_en_i(rd_en), .rd_data_o(rd_data), .rd_valid_o(rd_valid)
  );

  // configuration as seen from the requirements
  logic [31:0] sz   [6] = '{32'h1000, 32'h0010_0000, 32'h100, 32'h20, 32'h10, 32'h0001_0000};
  bit          io   [6] = '{0, 0, 1, 1, 0, 0};
  bit          io16 [6] = '{0, 0, 1, 0, 0, 0};
  logic [31:0] enc  [6] = '{32'h0, 32'h8, 32'h1, 32'h1, 32'h0, 32'h4};
  logic [31:0] model [6];

  logic [31:0] exp_q [$];
  string       tag_q [$];

  function automatic logic [31:0] amask(int i);
    logic [31:0] m = ~(sz[i] - 1);
    m &= io[i] ? 32'hFFFF_FFFC : 32'hFFFF_FFF0;
    if (io16[i]) m &= 32'h0000_FFFF;
    return m;
  endfunction

  function automatic logic [31:0] expv(int i);
    return (i < 6) ? (model[i] | enc[i]) : 32'h0;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%08h exp=%08h", tag, act, exp);
    end
  endtask

  task automatic do_wr(int i, logic [31:0] d, logic [3:0] be);
    @(negedge clk);
    idx = i[2:0]; wr_en = 1'b1; wr_data = d; wr_be = be;
    if (i < 6) begin
      logic [31:0] m = model[i];
      for (int b = 0; b < 4; b++) if (be[b]) m[8*b +: 8] = d[8*b +: 8];
      model[i] = m & amask(i);
    end
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic do_rd(int i, string tag);
    @(negedge clk);
    idx = i[2:0]; rd_en = 1'b1;
    exp_q.push_back(expv(i));
    tag_q.push_back(tag);
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  // read and write the same register in one cycle: old value expected
  task automatic do_rw(int i, logic [31:0] d, string tag);
    @(negedge clk);
    idx = i[2:0]; rd_en = 1'b1; wr_en = 1'b1; wr_data = d; wr_be = 4'hF;
    exp_q.push_back(expv(i));
    tag_q.push_back(tag);
    model[i] = d & amask(i);
    @(posedge clk); #1;
    rd_en = 1'b0; wr_en = 1'b0;
  endtask

  // monitor: scoreboard compare
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) chk("R9 unexpected valid", 32'h1, 32'h0);
      else chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 6; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R9 valid low after reset", {31'h0, rd_valid}, 32'h0);

    for (int i = 0; i < 8; i++) do_rd(i, (i < 6) ? "R1 reset value" : "R8 oob read");

    // probes
    for (int i = 0; i < 6; i++) begin
      do_wr(i, 32'hFFFF_FFFF, 4'hF);
      do_rd(i, io[i] ? "R5 R2 io probe" : "R4 R2 mem probe");
    end
    @(negedge clk); @(negedge clk);
    exp_q.push_back(32'hFFFF_F000); tag_q.push_back("R2 0x1000 probe literal");
    @(negedge clk); idx = 3'd0; rd_en = 1'b1; @(posedge clk); #1 rd_en = 1'b0;
    exp_q.push_back(32'h0000_FF01); tag_q.push_back("R6 io16 probe literal");
    @(negedge clk); idx = 3'd2; rd_en = 1'b1; @(posedge clk); #1 rd_en = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R6 io16 size from low half", (~model[2][15:0] + 16'd1) & 16'hFFFF, 32'h100);

    // write back base addresses
    do_wr(0, 32'h1234_5678, 4'hF); do_rd(0, "R3 write-back mem");
    do_wr(1, 32'hABCD_EF0F, 4'hF); do_rd(1, "R4 R3 attr kept");
    do_wr(2, 32'h5A5A_5A5A, 4'hF); do_rd(2, "R6 io16 upper zero");
    do_wr(3, 32'hFFFF_FFFE, 4'hF); do_rd(3, "R5 io bit1 zero");
    do_wr(4, 32'h0000_0007, 4'hF); do_rd(4, "R4 low bits ignored");
    @(negedge clk); @(negedge clk);
    exp_q.push_back(32'h1234_5000); tag_q.push_back("R3 literal restore");
    @(negedge clk); idx = 3'd0; rd_en = 1'b1; @(posedge clk); #1 rd_en = 1'b0;

    // byte enables
    do_wr(5, 32'h0, 4'hF);
    do_wr(5, 32'hFFFF_FFFF, 4'b0100); do_rd(5, "R7 lane2 only");
    do_wr(5, 32'h1122_3344, 4'b1001); do_rd(5, "R7 lanes 3 and 0");
    do_wr(0, 32'hFFFF_FFFF, 4'b0010); do_rd(0, "R7 lane1 masked");

    // out-of-range writes
    do_wr(6, 32'hFFFF_FFFF, 4'hF);
    do_wr(7, 32'h0, 4'hF);
    for (int i = 0; i < 8; i++) do_rd(i, "R8 oob write ignored");

    // same-cycle read and write
    do_rw(1, 32'hFFFF_FFFF, "R9 read sees old value");
    do_rd(1, "R9 write then visible");

    repeat (4) @(negedge clk);
    chk("R9 valid low when idle", {31'h0, rd_valid}, 32'h0);
    chk("R9 scoreboard drained", exp_q.size(), 32'h0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule